// File: doc/BRIEF.md
# LCD Controller Start-Up Sequencer

This block brings a character LCD controller out of power-on into 4-bit interface mode. Until the controller has been told which interface width to use, its busy flag cannot be read. The sequencer therefore first issues raw single-nibble writes separated by fixed delays. It then hands over to busy-flag polling for the remaining configuration bytes and raises `done`.

The block sits in front of a bus engine that actually toggles the LCD pins. It uses three request/acknowledge ports on that engine:

- a nibble-write port;
- a byte-write port;
- a wait-until-ready port.

Each request stays high, with its data stable, until the engine returns a one-cycle acknowledge. All delays are cycle counts derived from the clock frequency parameter, and each count is rounded up.

Top module: `lcd_init_seq`

## Requirements
- R1: After reset is released, no request is made for exactly ceil(PWR_US·CLK_HZ/10^6) cycles. The first request is then a nibble write with data 0x3.
- R2: After the first nibble is acknowledged, the block waits exactly ceil(MID_US·CLK_HZ/10^6) cycles and then sends a second nibble 0x3.
- R3: After the second nibble is acknowledged, the block waits exactly ceil(SHORT_US·CLK_HZ/10^6) cycles and then sends a third nibble 0x3.
- R4: In the cycle after the third nibble is acknowledged, the block requests a nibble write carrying the upper nibble of FUNC_BYTE (0x2 by default), with no delay.
- R5: From then on, each step is requested in the cycle after the previous acknowledge, in this order: ready poll, byte FUNC_BYTE (0x28), ready poll, byte DISP_BYTE (0x08), ready poll.
- R6: The register-select output `lcd_rs` is low for every write the block makes.
- R7: At most one request is high at any time. A request, and its data, stay unchanged until acknowledged.
- R8: `done` is low from reset until the final poll is acknowledged. It is high in the following cycle and stays high, with no requests, until a restart.
- R9: A one-cycle `start` pulse while `done` is high clears `done` and reruns the whole sequence from the power-up wait. `start` while the sequence is running has no effect on its order or timing.
- R10: Delay counts round up. With a clock that does not divide evenly, each wait is one cycle longer than the truncated product.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Restart pulse, honoured only when `done` is high |
| done | output | 1 | Sequence complete |
| lcd_rs | output | 1 | Register select for writes (always instruction) |
| nib_req | output | 1 | Nibble-write request |
| nib_data | output | 4 | Nibble to write |
| nib_ack | input | 1 | Nibble write finished |
| byte_req | output | 1 | Byte-write request |
| byte_data | output | 8 | Byte to write |
| byte_ack | input | 1 | Byte write finished |
| poll_req | output | 1 | Wait-until-ready request |
| poll_ack | input | 1 | Controller reported not busy |

## Verification
The bench runs with a clock of 1,100,001 Hz, so every delay product has a fraction. A design that truncated instead of rounding up would open each request one cycle early, and the exact gap comparison would catch this. The engine model acknowledges after varying latencies, including zero extra cycles. A design that advanced without waiting for the acknowledge, or that inserted a stray wait between the third 0x3 and the 0x2 nibble, would break the expected order or a zero gap. A `start` pulse injected during the 4.1 ms wait must leave the sequence untouched; a design that restarted there would replay the power-up wait. A restart after `done` must reproduce the full timed sequence.

// File: rtl/lcd_init_seq.sv
module lcd_init_seq #(
  parameter int unsigned CLK_HZ    = 50_000_000,
  parameter int unsigned PWR_US    = 15_000,
  parameter int unsigned MID_US    = 4_100,
  parameter int unsigned SHORT_US  = 100,
  parameter logic [7:0]  FUNC_BYTE = 8'h28,
  parameter logic [7:0]  DISP_BYTE = 8'h08
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  output logic       done,
  output logic       lcd_rs,
  output logic       nib_req,
  output logic [3:0] nib_data,
  input  logic       nib_ack,
  output logic       byte_req,
  output logic [7:0] byte_data,
  input  logic       byte_ack,
  output logic       poll_req,
  input  logic       poll_ack
);
  localparam longint unsigned PWR_CYC   = (64'(PWR_US)   * 64'(CLK_HZ) + 64'd999_999) / 64'd1_000_000;
  localparam longint unsigned MID_CYC   = (64'(MID_US)   * 64'(CLK_HZ) + 64'd999_999) / 64'd1_000_000;
  localparam longint unsigned SHORT_CYC = (64'(SHORT_US) * 64'(CLK_HZ) + 64'd999_999) / 64'd1_000_000;
  localparam longint unsigned MAX_CYC   = (PWR_CYC > MID_CYC) ? ((PWR_CYC > SHORT_CYC) ? PWR_CYC : SHORT_CYC)
                                                              : ((MID_CYC > SHORT_CYC) ? MID_CYC : SHORT_CYC);
  localparam int CW = $clog2(MAX_CYC + 1);
  localparam logic [3:0] WAKE_NIB = 4'h3;

  typedef enum logic [3:0] {
    S_PWR, S_N1, S_W1, S_N2, S_W2, S_N3, S_N4,
    S_P1, S_B1, S_P2, S_B2, S_P3, S_DONE
  } state_t;

  state_t        state;
  logic [CW-1:0] cnt;
  logic          cnt_zero;

  assign cnt_zero = (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_PWR;
      cnt   <= CW'(PWR_CYC - 1);
    end else begin
      case (state)
        S_PWR:  if (cnt_zero) state <= S_N1; else cnt <= cnt - 1'b1;
        S_N1:   if (nib_ack) begin state <= S_W1; cnt <= CW'(MID_CYC - 1); end
        S_W1:   if (cnt_zero) state <= S_N2; else cnt <= cnt - 1'b1;
        S_N2:   if (nib_ack) begin state <= S_W2; cnt <= CW'(SHORT_CYC - 1); end
        S_W2:   if (cnt_zero) state <= S_N3; else cnt <= cnt - 1'b1;
        S_N3:   if (nib_ack) state <= S_N4;
        S_N4:   if (nib_ack) state <= S_P1;
        S_P1:   if (poll_ack) state <= S_B1;
        S_B1:   if (byte_ack) state <= S_P2;
        S_P2:   if (poll_ack) state <= S_B2;
        S_B2:   if (byte_ack) state <= S_P3;
        S_P3:   if (poll_ack) state <= S_DONE;
        S_DONE: if (start) begin state <= S_PWR; cnt <= CW'(PWR_CYC - 1); end
        default: state <= S_PWR;
      endcase
    end
  end

  assign nib_req   = (state == S_N1) || (state == S_N2) || (state == S_N3) || (state == S_N4);
  assign nib_data  = (state == S_N4) ? FUNC_BYTE[7:4] : WAKE_NIB;
  assign byte_req  = (state == S_B1) || (state == S_B2);
  assign byte_data = (state == S_B1) ? FUNC_BYTE : DISP_BYTE;
  assign poll_req  = (state == S_P1) || (state == S_P2) || (state == S_P3);
  assign done      = (state == S_DONE);
  assign lcd_rs    = 1'b0;

  assert_single_req_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({nib_req, byte_req, poll_req}));
  assert_nib_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    nib_req && !nib_ack |=> nib_req && $stable(nib_data));
  assert_byte_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    byte_req && !byte_ack |=> byte_req && $stable(byte_data));
  assert_poll_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    poll_req && !poll_ack |=> poll_req);
  assert_done_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done && !start |=> done);
  assert_done_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !(nib_req || byte_req || poll_req));
  assert_restart_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done && start |=> !done && !nib_req);
  assert_final_poll_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(poll_req && poll_ack));
endmodule

// File: tb/lcd_init_seq_bench.sv
module lcd_init_seq_bench;
  localparam int unsigned HZ = 1_100_001;
  // R10: ceil products for HZ: 15000us -> 16501, 4100us -> 4511, 100us -> 111
  localparam int PWR_GAP = 16501;
  localparam int MID_GAP = 4511;
  localparam int SHORT_GAP = 111;

  typedef struct {
    int    kind;   // 0 nibble, 1 byte, 2 poll
    int    data;
    int    gap;
    string req;
  } item_t;

  logic       clk = 0, rst_n = 0, start = 0;
  logic       done, lcd_rs, nib_req, byte_req, poll_req;
  logic [3:0] nib_data;
  logic [7:0] byte_data;
  logic       nib_ack = 0, byte_ack = 0, poll_ack = 0;

  int checks = 0, errors = 0;
  item_t q[$];

  always #2 clk = ~clk;

  lcd_init_seq #(.CLK_HZ(HZ)) u_lcd_init_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .done(done), .lcd_rs(lcd_rs),
    .nib_req(nib_req), .nib_data(nib_data), .nib_ack(nib_ack),
    .byte_req(byte_req), .byte_data(byte_data), .byte_ack(byte_ack),
    .poll_req(poll_req), .poll_ack(poll_ack)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic push(input int kind, input int data, input int gap, input string req);
    item_t it;
    it.kind = kind; it.data = data; it.gap = gap; it.req = req;
    q.push_back(it);
  endtask

  task automatic push_seq();
    push(0, 4'h3, PWR_GAP, "R1");
    push(0, 4'h3, MID_GAP, "R2");
    push(0, 4'h3, SHORT_GAP, "R3");
    push(0, 4'h2, 0, "R4");
    push(2, 0, 0, "R5");
    push(1, 8'h28, 0, "R5");
    push(2, 0, 0, "R5");
    push(1, 8'h08, 0, "R5");
    push(2, 0, 0, "R5");
  endtask

  int  gap = 0, lat = 0, ntx = 0;
  bit  active = 0;
  int  cur_kind = 0, cur_data = 0;

  function automatic int req_kind();
    if (nib_req) return 0;
    if (byte_req) return 1;
    if (poll_req) return 2;
    return -1;
  endfunction

  function automatic int req_data();
    if (nib_req) return int'(nib_data);
    if (byte_req) return int'(byte_data);
    return 0;
  endfunction

  task automatic raise_ack();
    if (cur_kind == 0) nib_ack = 1;
    else if (cur_kind == 1) byte_ack = 1;
    else poll_ack = 1;
  endtask

  always @(negedge clk) begin
    if (!rst_n) begin
      gap = 0; active = 0; nib_ack = 0; byte_ack = 0; poll_ack = 0;
    end else begin
      if (nib_ack || byte_ack || poll_ack) begin
        nib_ack = 0; byte_ack = 0; poll_ack = 0;
        active = 0;
        // R8: done exactly one cycle after the last poll acknowledge
        check(done == (cur_kind == 2 && q.size() == 0), "R8", done, (cur_kind == 2 && q.size() == 0));
      end else if (active) begin
        if (req_kind() != cur_kind || req_data() != cur_data) begin
          check(0, "R7", req_data(), cur_data);
        end
        if (lat == 0) raise_ack(); else lat--;
      end
      if (!active) begin
        if (req_kind() < 0) begin
          if (start && done) gap = 0; else gap++;
        end else begin
          item_t e;
          cur_kind = req_kind();
          cur_data = req_data();
          if (q.size() == 0) begin
            check(0, "R8", cur_kind, -1);
          end else begin
            e = q.pop_front();
            check(cur_kind == e.kind, e.req, cur_kind, e.kind);
            check(cur_data == e.data, e.req, cur_data, e.data);
            check(gap == e.gap, e.req, gap, e.gap);
            check(lcd_rs == 1'b0, "R6", lcd_rs, 0);
          end
          active = 1;
          gap = 0;
          lat = ntx % 4;
          ntx++;
          if (lat == 0) raise_ack(); else lat--;
        end
      end
    end
  end

  task automatic wait_done();
    while (!done) @(negedge clk);
  endtask

  task automatic quiet_done(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      check(done && !nib_req && !byte_req && !poll_req, "R8", done, 1);
    end
  endtask

  task automatic pulse_start();
    @(posedge clk); #1 start = 1;
    @(posedge clk); #1 start = 0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(!done && !nib_req && !byte_req && !poll_req, "R8", done, 0);
    push_seq();
    @(posedge clk); #1 rst_n = 1;
    wait_done();
    check(q.size() == 0, "R5", q.size(), 0);
    quiet_done(20);
    // R9: restart after done, then a start pulse mid-run that must be ignored
    push_seq();
    pulse_start();
    @(negedge clk);
    check(!done, "R9", done, 0);
    repeat (PWR_GAP + 200) @(posedge clk);
    #1 start = 1;
    @(posedge clk); #1 start = 0;
    wait_done();
    check(q.size() == 0, "R9", q.size(), 0);
    quiet_done(10);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog R8 actual=%0d expected=%0d", done, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule